// File: doc/BRIEF.md
# Saturating Dual-Accumulator Arithmetic Unit

This block holds two wide signed accumulators and applies one arithmetic, compare or selection command to them per clock. Each accumulator is made of a signed pair-width value (two data words) plus guard bits above it. Arithmetic is always done on the sign-extended accumulator contents. When the saturation input is high, results are clamped to the signed pair-width range. When it is low, they wrap to the full accumulator width.

A command names an operation, a destination accumulator and the second operand. The second operand is either the other accumulator or a register-pair value that comes in with the command: a signed high word above an unsigned low word. There is also a shifted add, which adds the other accumulator arithmetically shifted right by one word width. Compare, minimum and maximum update two condition flags.

The command port is a valid/ready stream. Ready is held high at all times, so there is never back-pressure. A command is taken on every rising edge where valid is high, and its result is visible on the outputs right after that edge. Back-to-back commands take one cycle each.

Top module: `acc_sat_unit`

## Requirements
- R1: A synchronous reset clears both accumulators and both flags, and a command presented during reset has no effect.
- R2: Ready is always high. A command with valid high updates state at the next rising edge, one command per cycle. With valid low nothing changes. Opcode values: 0 load, 1 add, 2 subtract, 3 shifted add, 4 absolute value, 5 negate, 6 signed less-than compare, 7 equality compare, 8 minimum, 9 maximum.
- R3: Load writes the pair operand to the destination: the sign-extended high word (pair bits above the low word) joined with the zero-extended low word.
- R4: Add and subtract compute destination plus or minus the second operand. The second operand is the other accumulator when the pair-select input is 0 and the pair value when it is 1. Both operands are sign-extended from their top bit.
- R5: With saturation enabled, an add, subtract, shifted add, negate or absolute-value result above the largest signed pair-width value is written as that value. A result below the smallest signed pair-width value is written as that value. Both are sign-extended to accumulator width.
- R6: With saturation disabled, the result is the low accumulator-width bits of the exact result.
- R7: Shifted add adds the other accumulator, arithmetically shifted right by the word width, to the destination and applies R5/R6. The pair-select input is ignored.
- R8: Negate writes the negated destination under R5/R6. Absolute value negates a negative destination under R5/R6 and leaves a non-negative destination unchanged, even when it lies beyond the clamp limit.
- R9: The less-than compare sets F0 when the destination is signed-less than the second operand. The equality compare sets F0 on an exact match. Both leave F1 and the accumulators unchanged.
- R10: Minimum and maximum copy the old F0 into F1. They replace the destination with the second operand only when that operand is strictly smaller (minimum) or strictly larger (maximum), and set F0 to 1 when a replacement happened and 0 otherwise. No saturation is applied.
- R11: Load, add, subtract, shifted add, absolute value and negate leave both flags unchanged, and no command changes the non-destination accumulator.
- R12: Opcodes 10 to 15 are taken but change no accumulator and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command ready, held high |
| cmd_op_i | input | 4 | Operation code |
| cmd_dst_i | input | 1 | Destination accumulator (0 or 1) |
| cmd_src_pair_i | input | 1 | Second operand: 0 other accumulator, 1 pair value |
| cmd_pair_i | input | 2*WORD_W | Register-pair value, high word above low word |
| sat_en_i | input | 1 | Saturation enable |
| acc0_o | output | 2*WORD_W+GUARD_W | Accumulator 0 |
| acc1_o | output | 2*WORD_W+GUARD_W | Accumulator 1 |
| f0_o | output | 1 | Flag F0 |
| f1_o | output | 1 | Flag F1 |

## Verification
The bench builds the unit with WORD_W=4 and GUARD_W=2. That gives 10-bit accumulators, 8-bit pair operands and clamp limits of +127 and -128. At this size, absolute value and negate are swept over every one of the 1024 accumulator values, with and without saturation. That includes the most negative value, whose negation overflows the guard band. The binary operations run over a grid of guard-band, clamp-edge and interior values, with both operand sources and both saturation settings, so every clamp and wrap boundary is reached.

// File: rtl/acc_sat_pkg.sv
package acc_sat_pkg;

  typedef enum logic [3:0] {
    ACC_OP_LOAD  = 4'd0,
    ACC_OP_ADD   = 4'd1,
    ACC_OP_SUB   = 4'd2,
    ACC_OP_SADD  = 4'd3,
    ACC_OP_ABS   = 4'd4,
    ACC_OP_NEG   = 4'd5,
    ACC_OP_CMPLT = 4'd6,
    ACC_OP_CMPEQ = 4'd7,
    ACC_OP_MIN   = 4'd8,
    ACC_OP_MAX   = 4'd9
  } acc_op_e;

  localparam int ACC_NUM = 2;

endpackage

// File: rtl/acc_opnd_sel.sv
module acc_opnd_sel #(
  parameter int WORD_W  = 16,
  parameter int GUARD_W = 8,
  localparam int PAIR_W = 2 * WORD_W,
  localparam int ACC_W  = PAIR_W + GUARD_W
) (
  input  logic [ACC_W-1:0]  acc0,
  input  logic [ACC_W-1:0]  acc1,
  input  logic              dst_sel,
  input  logic              src_pair,
  input  logic [PAIR_W-1:0] pair,
  output logic [ACC_W-1:0]  dst_val,
  output logic [ACC_W-1:0]  src_val,
  output logic [ACC_W-1:0]  pair_val,
  output logic [ACC_W-1:0]  shf_val
);

  logic [WORD_W-1:0] hi_word;
  logic [WORD_W-1:0] lo_word;
  logic [ACC_W-1:0]  oth_val;

  // signed high word above an unsigned low word
  assign hi_word  = pair[PAIR_W-1:WORD_W];
  assign lo_word  = pair[WORD_W-1:0];
  assign pair_val = {{GUARD_W{hi_word[WORD_W-1]}}, hi_word, lo_word};

  assign dst_val = dst_sel ? acc1 : acc0;
  assign oth_val = dst_sel ? acc0 : acc1;
  assign src_val = src_pair ? pair_val : oth_val;

  // other accumulator, arithmetic shift right by one word
  assign shf_val = ACC_W'($signed(oth_val) >>> WORD_W);

endmodule

// File: rtl/acc_sat_clamp.sv
module acc_sat_clamp #(
  parameter int ACC_W  = 40,
  parameter int PAIR_W = 32,
  localparam int EXT_W = ACC_W + 2
) (
  input  logic signed [EXT_W-1:0] wide,
  input  logic                    sat_en,
  output logic [ACC_W-1:0]        res
);

  localparam logic signed [EXT_W-1:0] LIM_HI =
    {{(EXT_W-PAIR_W+1){1'b0}}, {(PAIR_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] LIM_LO =
    {{(EXT_W-PAIR_W+1){1'b1}}, {(PAIR_W-1){1'b0}}};

  logic above;
  logic below;

  assign above = wide > LIM_HI;
  assign below = wide < LIM_LO;

  always_comb begin
    if (sat_en && above)      res = LIM_HI[ACC_W-1:0];
    else if (sat_en && below) res = LIM_LO[ACC_W-1:0];
    else                      res = wide[ACC_W-1:0];
  end

endmodule

// File: rtl/acc_sat_alu.sv
module acc_sat_alu
  import acc_sat_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int PAIR_W = 32,
  localparam int EXT_W = ACC_W + 2
) (
  input  acc_op_e          op,
  input  logic [ACC_W-1:0] dst_val,
  input  logic [ACC_W-1:0] src_val,
  input  logic [ACC_W-1:0] pair_val,
  input  logic [ACC_W-1:0] shf_val,
  input  logic             sat_en,
  output logic [ACC_W-1:0] res,
  output logic             wr
);

  logic signed [EXT_W-1:0] dx;
  logic signed [EXT_W-1:0] sx;
  logic signed [EXT_W-1:0] px;
  logic signed [EXT_W-1:0] hx;
  logic signed [EXT_W-1:0] wide;
  logic                    dst_neg;
  logic                    sat_eff;

  assign dx = {{2{dst_val[ACC_W-1]}}, dst_val};
  assign sx = {{2{src_val[ACC_W-1]}}, src_val};
  assign px = {{2{pair_val[ACC_W-1]}}, pair_val};
  assign hx = {{2{shf_val[ACC_W-1]}}, shf_val};
  assign dst_neg = dst_val[ACC_W-1];

  always_comb begin
    wide = dx;
    wr   = 1'b1;
    case (op)
      ACC_OP_LOAD: wide = px;
      ACC_OP_ADD:  wide = dx + sx;
      ACC_OP_SUB:  wide = dx - sx;
      ACC_OP_SADD: wide = dx + hx;
      ACC_OP_ABS:  wide = dst_neg ? -dx : dx;
      ACC_OP_NEG:  wide = -dx;
      default:     wr   = 1'b0;
    endcase
  end

  // a non-negative value passes through absolute value untouched
  assign sat_eff = sat_en && !(op == ACC_OP_ABS && !dst_neg);

  acc_sat_clamp #(
    .ACC_W  (ACC_W),
    .PAIR_W (PAIR_W)
  ) u_clamp (
    .wide   (wide),
    .sat_en (sat_eff),
    .res    (res)
  );

endmodule

// File: rtl/acc_cmp_unit.sv
module acc_cmp_unit #(
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] dst_val,
  input  logic [ACC_W-1:0] src_val,
  output logic             dst_lt_src,
  output logic             dst_eq_src,
  output logic             src_lt_dst,
  output logic             src_gt_dst
);

  logic signed [ACC_W-1:0] d_s;
  logic signed [ACC_W-1:0] s_s;

  assign d_s = dst_val;
  assign s_s = src_val;

  assign dst_lt_src = d_s < s_s;
  assign dst_eq_src = dst_val == src_val;
  assign src_lt_dst = s_s < d_s;
  assign src_gt_dst = s_s > d_s;

endmodule

// File: rtl/acc_sat_unit.sv
module acc_sat_unit
  import acc_sat_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int GUARD_W = 8,
  localparam int PAIR_W = 2 * WORD_W,
  localparam int ACC_W  = PAIR_W + GUARD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [3:0]        cmd_op_i,
  input  logic              cmd_dst_i,
  input  logic              cmd_src_pair_i,
  input  logic [PAIR_W-1:0] cmd_pair_i,
  input  logic              sat_en_i,
  output logic [ACC_W-1:0]  acc0_o,
  output logic [ACC_W-1:0]  acc1_o,
  output logic              f0_o,
  output logic              f1_o
);

  acc_op_e                       op;
  logic                          fire;
  logic [ACC_NUM-1:0][ACC_W-1:0] acc_q;
  logic                          f0_q;
  logic                          f1_q;

  logic [ACC_W-1:0] dst_val;
  logic [ACC_W-1:0] src_val;
  logic [ACC_W-1:0] pair_val;
  logic [ACC_W-1:0] shf_val;
  logic [ACC_W-1:0] alu_res;
  logic             alu_wr;
  logic             dst_lt_src;
  logic             dst_eq_src;
  logic             src_lt_dst;
  logic             src_gt_dst;

  logic [ACC_W-1:0] wr_val;
  logic             wr_en;
  logic             f0_n;
  logic             f1_n;

  assign op          = acc_op_e'(cmd_op_i);
  assign cmd_ready_o = 1'b1;
  assign fire        = cmd_valid_i && cmd_ready_o;

  acc_opnd_sel #(
    .WORD_W  (WORD_W),
    .GUARD_W (GUARD_W)
  ) u_opnd (
    .acc0     (acc_q[0]),
    .acc1     (acc_q[1]),
    .dst_sel  (cmd_dst_i),
    .src_pair (cmd_src_pair_i),
    .pair     (cmd_pair_i),
    .dst_val  (dst_val),
    .src_val  (src_val),
    .pair_val (pair_val),
    .shf_val  (shf_val)
  );

  acc_sat_alu #(
    .ACC_W  (ACC_W),
    .PAIR_W (PAIR_W)
  ) u_alu (
    .op       (op),
    .dst_val  (dst_val),
    .src_val  (src_val),
    .pair_val (pair_val),
    .shf_val  (shf_val),
    .sat_en   (sat_en_i),
    .res      (alu_res),
    .wr       (alu_wr)
  );

  acc_cmp_unit #(
    .ACC_W (ACC_W)
  ) u_cmp (
    .dst_val    (dst_val),
    .src_val    (src_val),
    .dst_lt_src (dst_lt_src),
    .dst_eq_src (dst_eq_src),
    .src_lt_dst (src_lt_dst),
    .src_gt_dst (src_gt_dst)
  );

  always_comb begin
    wr_en  = alu_wr;
    wr_val = alu_res;
    f0_n   = f0_q;
    f1_n   = f1_q;
    case (op)
      ACC_OP_CMPLT: f0_n = dst_lt_src;
      ACC_OP_CMPEQ: f0_n = dst_eq_src;
      ACC_OP_MIN: begin
        f1_n   = f0_q;
        f0_n   = src_lt_dst;
        wr_en  = src_lt_dst;
        wr_val = src_val;
      end
      ACC_OP_MAX: begin
        f1_n   = f0_q;
        f0_n   = src_gt_dst;
        wr_en  = src_gt_dst;
        wr_val = src_val;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      f0_q  <= 1'b0;
      f1_q  <= 1'b0;
    end else if (fire) begin
      for (int k = 0; k < ACC_NUM; k++) begin
        if (wr_en && (int'(cmd_dst_i) == k)) acc_q[k] <= wr_val;
      end
      f0_q <= f0_n;
      f1_q <= f1_n;
    end
  end

  assign acc0_o = acc_q[0];
  assign acc1_o = acc_q[1];
  assign f0_o   = f0_q;
  assign f1_o   = f1_q;

endmodule

// File: rtl/acc_sat_unit_chk.sv
module acc_sat_unit_chk
  import acc_sat_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int GUARD_W = 8,
  localparam int PAIR_W = 2 * WORD_W,
  localparam int ACC_W  = PAIR_W + GUARD_W
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid_i,
  input logic [3:0]       cmd_op_i,
  input logic             cmd_dst_i,
  input logic             sat_en_i,
  input logic [ACC_W-1:0] acc0_o,
  input logic [ACC_W-1:0] acc1_o,
  input logic             f0_o,
  input logic             f1_o
);

  localparam logic signed [ACC_W-1:0] BOUND_HI =
    {{(GUARD_W+1){1'b0}}, {(PAIR_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] BOUND_LO =
    {{(GUARD_W+1){1'b1}}, {(PAIR_W-1){1'b0}}};

  logic clamped_op;
  logic flag_free_op;
  logic minmax_op;
  logic cmp_op;

  assign clamped_op = cmd_op_i == ACC_OP_ADD || cmd_op_i == ACC_OP_SUB ||
                      cmd_op_i == ACC_OP_SADD || cmd_op_i == ACC_OP_NEG;
  assign flag_free_op = clamped_op || cmd_op_i == ACC_OP_LOAD ||
                        cmd_op_i == ACC_OP_ABS;
  assign minmax_op = cmd_op_i == ACC_OP_MIN || cmd_op_i == ACC_OP_MAX;
  assign cmp_op    = cmd_op_i == ACC_OP_CMPLT || cmd_op_i == ACC_OP_CMPEQ;

  function automatic logic within_bounds(input logic [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] s;
    s = v;
    return (s <= BOUND_HI) && (s >= BOUND_LO);
  endfunction

  // R2: without a valid command all state holds
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(cmd_valid_i) |-> $stable(acc0_o) && $stable(acc1_o) &&
                            $stable(f0_o) && $stable(f1_o));

  // R5: saturated results stay within the signed pair-width range
  assert_sat_bound_R5: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_valid_i && sat_en_i && clamped_op) |->
      within_bounds($past(cmd_dst_i) ? acc1_o : acc0_o));

  // R11: arithmetic and load leave the flags alone
  assert_flags_kept_R11: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_valid_i && flag_free_op) |-> $stable(f0_o) && $stable(f1_o));

  // R11: the non-destination accumulator never changes
  assert_other0_kept_R11: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_valid_i && cmd_dst_i) |-> $stable(acc0_o));

  assert_other1_kept_R11: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_valid_i && !cmd_dst_i) |-> $stable(acc1_o));

  // R10: min and max move the old F0 into F1
  assert_f1_shift_R10: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_valid_i && minmax_op) |-> f1_o == $past(f0_o));

  // R9: compares touch neither accumulator nor F1
  assert_cmp_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_valid_i && cmp_op) |->
      $stable(acc0_o) && $stable(acc1_o) && $stable(f1_o));

endmodule

bind acc_sat_unit acc_sat_unit_chk #(
  .WORD_W  (WORD_W),
  .GUARD_W (GUARD_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_dst_i   (cmd_dst_i),
  .sat_en_i    (sat_en_i),
  .acc0_o      (acc0_o),
  .acc1_o      (acc1_o),
  .f0_o        (f0_o),
  .f1_o        (f1_o)
);

// File: tb/acc_sat_unit_tb.sv
module acc_sat_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 4;
  localparam int GUARD_W    = 2;
  localparam int PAIR_W     = 2 * WORD_W;
  localparam int ACC_W      = PAIR_W + GUARD_W;
  localparam int SAT_MAX    = (1 << (PAIR_W - 1)) - 1;
  localparam int SAT_MIN    = -(1 << (PAIR_W - 1));
  localparam int ACC_MIN    = -(1 << (ACC_W - 1));
  localparam int ACC_MAX    = (1 << (ACC_W - 1)) - 1;
  localparam int WATCHDOG   = 190000;
  localparam int NGRID      = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid_i = 1'b0;
  logic              cmd_ready_o;
  logic [3:0]        cmd_op_i = '0;
  logic              cmd_dst_i = 1'b0;
  logic              cmd_src_pair_i = 1'b0;
  logic [PAIR_W-1:0] cmd_pair_i = '0;
  logic              sat_en_i = 1'b0;
  logic [ACC_W-1:0]  acc0_o;
  logic [ACC_W-1:0]  acc1_o;
  logic              f0_o;
  logic              f1_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  int  m[2];
  int  mf0 = 0;
  int  mf1 = 0;
  bit  done = 1'b0;

  acc_sat_unit #(
    .WORD_W  (WORD_W),
    .GUARD_W (GUARD_W)
  ) u_dut (
    .clk            (clk),
    .rst            (rst),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_ready_o    (cmd_ready_o),
    .cmd_op_i       (cmd_op_i),
    .cmd_dst_i      (cmd_dst_i),
    .cmd_src_pair_i (cmd_src_pair_i),
    .cmd_pair_i     (cmd_pair_i),
    .sat_en_i       (sat_en_i),
    .acc0_o         (acc0_o),
    .acc1_o         (acc1_o),
    .f0_o           (f0_o),
    .f1_o           (f1_o)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int sx(input int v);
    int t;
    t = v & ((1 << ACC_W) - 1);
    return (t >= (1 << (ACC_W - 1))) ? t - (1 << ACC_W) : t;
  endfunction

  function automatic int ps(input int p);
    int t;
    t = p & ((1 << PAIR_W) - 1);
    return (t >= (1 << (PAIR_W - 1))) ? t - (1 << PAIR_W) : t;
  endfunction

  function automatic int clampf(input int r, input bit en);
    if (en && r > SAT_MAX) return SAT_MAX;
    if (en && r < SAT_MIN) return SAT_MIN;
    return sx(r);
  endfunction

  function automatic int pick(input int i);
    int corner[12] = '{ACC_MIN, ACC_MIN + 1, SAT_MIN - 1, SAT_MIN, SAT_MIN + 1,
                       -1, 0, 1, SAT_MAX - 1, SAT_MAX, SAT_MAX + 1, ACC_MAX};
    if (i < 12) return corner[i];
    return -500 + (i - 12) * 89;
  endfunction

  task automatic check_state(input string tag);
    int a0, a1;
    a0 = sx(int'(acc0_o));
    a1 = sx(int'(acc1_o));
    n_cmp++;
    if (a0 !== m[0] || a1 !== m[1] || int'(f0_o) !== mf0 || int'(f1_o) !== mf1 ||
        cmd_ready_o !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: actual acc0=%0d acc1=%0d f0=%0d f1=%0d rdy=%0d expected %0d %0d %0d %0d 1",
               tag, a0, a1, f0_o, f1_o, cmd_ready_o, m[0], m[1], mf0, mf1);
    end
  endtask

  // one command per cycle; valid stays high between back-to-back calls
  task automatic issue(input int op, input int d, input bit sp, input int pair,
                       input bit sat, input string tag);
    int a, o, s;
    @(negedge clk);
    cmd_valid_i    = 1'b1;
    cmd_op_i       = 4'(op);
    cmd_dst_i      = d[0];
    cmd_src_pair_i = sp;
    cmd_pair_i     = PAIR_W'(pair);
    sat_en_i       = sat;
    a = m[d];
    o = m[1 - d];
    s = sp ? ps(pair) : o;
    case (op)
      0: m[d] = ps(pair);
      1: m[d] = clampf(a + s, sat);
      2: m[d] = clampf(a - s, sat);
      3: m[d] = clampf(a + (o >>> WORD_W), sat);
      4: if (a < 0) m[d] = clampf(-a, sat);
      5: m[d] = clampf(-a, sat);
      6: mf0 = (a < s) ? 1 : 0;
      7: mf0 = (a == s) ? 1 : 0;
      8: begin mf1 = mf0; mf0 = (s < a) ? 1 : 0; if (s < a) m[d] = s; end
      9: begin mf1 = mf0; mf0 = (s > a) ? 1 : 0; if (s > a) m[d] = s; end
      default: ;
    endcase
    @(posedge clk);
    #1;
    check_state(tag);
  endtask

  task automatic idle(input int cycles);
    @(negedge clk);
    cmd_valid_i = 1'b0;
    cmd_op_i    = 4'd0;
    cmd_pair_i  = PAIR_W'(8'h5A);
    repeat (cycles) @(posedge clk);
    #1;
  endtask

  // loads 0, then adds pair-sized steps without saturation (R3, R4)
  task automatic set_acc(input int d, input int v);
    int rem, step;
    issue(0, d, 1'b0, 0, 1'b0, "R3");
    rem = v;
    while (rem != 0) begin
      step = (rem > SAT_MAX) ? SAT_MAX : (rem < SAT_MIN) ? SAT_MIN : rem;
      issue(1, d, 1'b1, step, 1'b0, "R4");
      rem -= step;
    end
  endtask

  task automatic do_reset(input bit with_cmd);
    @(negedge clk);
    rst         = 1'b1;
    cmd_valid_i = with_cmd;
    cmd_op_i    = 4'd0;
    cmd_dst_i   = 1'b0;
    cmd_pair_i  = PAIR_W'(8'h37);
    repeat (3) @(posedge clk);
    m[0] = 0; m[1] = 0; mf0 = 0; mf1 = 0;
    #1;
    check_state("R1");
    @(negedge clk);
    cmd_valid_i = 1'b0;
    rst         = 1'b0;
    @(posedge clk);
    #1;
    check_state("R1");
  endtask

  function automatic string bin_tag(input int op, input bit sat);
    if (op == 3) return "R7";
    if (op >= 8) return "R10";
    return sat ? "R5" : "R6";
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m[0] = 0;
    m[1] = 0;
    do_reset(1'b0);

    // R3: pair 0x8F -> high word negative, low word unsigned
    issue(0, 0, 1'b0, 'h8F, 1'b0, "R3");
    issue(0, 1, 1'b1, 'h70, 1'b1, "R3");
    // R2: valid low leaves state untouched
    idle(3);
    check_state("R2");
    // R12: unused opcodes do nothing
    issue(15, 0, 1'b1, 'h33, 1'b1, "R12");
    issue(10, 1, 1'b0, 'h01, 1'b0, "R12");
    // R11: flags survive arithmetic, other acc untouched
    issue(6, 0, 1'b0, 0, 1'b0, "R9");
    issue(9, 0, 1'b1, 'h7F, 1'b0, "R10");
    issue(1, 1, 1'b1, 'h05, 1'b1, "R11");
    issue(5, 0, 1'b0, 0, 1'b1, "R11");
    issue(3, 1, 1'b1, 'h00, 1'b0, "R7");
    // R1: reset with a command pending
    do_reset(1'b1);

    // unary sweep over every accumulator value (R8)
    for (int v = ACC_MIN; v <= ACC_MAX; v++) begin
      for (int op = 4; op <= 5; op++) begin
        for (int sat = 0; sat < 2; sat++) begin
          set_acc(v & 1, v);
          issue(op, v & 1, 1'b0, 0, sat[0], "R8");
        end
      end
    end

    // binary grid (R4..R7, R9, R10)
    for (int i = 0; i < NGRID; i++) begin
      for (int j = 0; j < NGRID; j++) begin
        int a, b, d;
        a = pick(i);
        b = pick(j);
        d = (i + j) & 1;
        set_acc(d, a);
        set_acc(1 - d, b);
        issue(6, d, 1'b0, 0, 1'b0, "R9");
        issue(7, d, 1'b0, 0, 1'b0, "R9");
        issue(6, d, 1'b1, b, 1'b0, "R9");
        issue(7, d, 1'b1, a, 1'b0, "R9");
        for (int op = 1; op <= 9; op++) begin
          if (op >= 4 && op <= 7) continue;
          for (int sat = 0; sat < 2; sat++) begin
            for (int sp = 0; sp < 2; sp++) begin
              if (op == 3 && sp == 1) continue;
              set_acc(d, a);
              issue(op, d, sp[0], b, sat[0], bin_tag(op, sat[0]));
            end
          end
        end
      end
    end

    idle(2);
    check_state("R2");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule